// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block turns a stream of bytes into a low-speed USB packet on the D+ and D- lines. It drives the bus out of idle and sends a sync byte of its own first. It then serialises every payload byte least-significant bit first with NRZI coding and bit stuffing. It ends with the end-of-packet sequence and releases the bus. Every line event happens on a bit-rate clock enable, so the block runs on any system clock that is an integer multiple of the 1.5 Mbit/s bit rate. CRC generation and transaction scheduling belong to the logic around it.

Payload bytes arrive on a valid/ready stream with a last flag. A single holding register sits between the stream and the shift register. The source may present the next byte at any time, and the block takes it while the current byte is on the wire, so bytes follow one another without gaps. Back-pressure: `s_ready` is low while the holding register is full, after the byte flagged last has been accepted, after an underrun has been detected, and throughout the end-of-packet sequence. If the holding register is empty when the last bit of a byte leaves, the packet is cut short with a normal end-of-packet. A handshake packet is a single stream byte (the PID) with the last flag set.

Top module: `ls_pkt_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `bus_oe` and `busy` are low, `bus_dp` and `bus_dm` are low, and `s_ready` is high while no byte is held.
- R2: A packet starts only while `busy` is low. At the first bit tick that finds a byte held, `bus_oe` rises and the bus shows J (`bus_dp`=0, `bus_dm`=1) for one bit period before the first sync bit.
- R3: The first byte on the wire is the sync byte 0x80, which the block generates itself. Sent LSB first, it appears as K J K J K J K K.
- R4: NRZI coding: a 0 bit flips the line between J and K, and a 1 bit keeps the level. K is `bus_dp`=1, `bus_dm`=0. While driving, both lines are never high together.
- R5: Payload bytes go out LSB first in the order they were accepted, with no idle bit between consecutive bytes.
- R6: After six consecutive 1 bits on the wire, one extra bit period with a line flip is inserted. The run count restarts on every flip, and it carries across the boundary between the sync byte and the payload and across byte boundaries.
- R7: If the final payload bit completes a run of six 1s, the stuffed bit is still sent before end-of-packet.
- R8: End-of-packet is exactly two bit periods of SE0 (both lines low), then one bit period of J, then `bus_oe` falls at the next bit tick.
- R9: Once the byte flagged by `s_last` has been accepted, `s_ready` stays low until the bus is released.
- R10: If no byte is held or offered when the last bit of a byte goes out, the packet ends with the end-of-packet sequence of R8. `s_ready` stays low until release, and a byte offered meanwhile starts a new packet afterwards.
- R11: `busy` is high exactly while `bus_oe` is high.
- R12: `bus_oe`, `bus_dp` and `bus_dm` change only on clock edges at which `bit_en` is high.
- R13: A single stream byte flagged last yields a two-byte handshake packet: sync, then that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per bit period |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| s_data | input | DATA_W | Stream byte |
| s_last | input | 1 | Marks the final byte of the packet |
| busy | output | 1 | Packet in progress (bus acquired) |
| bus_oe | output | 1 | Output enable for the D+/D- drivers |
| bus_dp | output | 1 | Value driven on D+ |
| bus_dm | output | 1 | Value driven on D- |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a stuffing run of six and two bit periods of SE0. It pulses `bit_en` every fourth clock, so several stream handshakes can land inside one bit period. This reaches the bypass in which a byte arrives in the same cycle as the byte boundary, as well as the plain holding-register path. Those defaults make the stuffing run reachable from the sync byte's trailing 1 and across byte boundaries. They also allow a run that ends on the final payload bit. With a source that goes quiet in mid-packet, the underrun path and a byte offered during end-of-packet can both be seen at the ports.

// File: rtl/lstx_pkg.sv
package lstx_pkg;

  // What the bus shows during the current bit period.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // outputs released
    ST_PREJ = 3'd1,  // bus acquired, J before sync
    ST_DATA = 3'd2,  // sync, payload or stuffed bit
    ST_SE0  = 3'd3,  // end-of-packet, both lines low
    ST_EOPJ = 3'd4   // closing J before release
  } tx_state_e;

endpackage

// File: rtl/lstx_feed.sv
module lstx_feed #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              accept_en,  // sequencer in a state that takes bytes
  input  logic              take,       // last bit of current byte leaves now
  input  logic              finish,     // bus released this cycle
  output logic              pending,    // a byte is held
  output logic              have,       // a byte is available for take
  output logic [DATA_W-1:0] nxt_data
);

  logic              hold_full;
  logic              closed;
  logic [DATA_W-1:0] hold;
  logic              fire;

  assign s_ready  = accept_en && !hold_full && !closed;
  assign fire     = s_valid && s_ready;
  assign have     = hold_full || fire;
  assign nxt_data = hold_full ? hold : s_data;
  assign pending  = hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      closed    <= 1'b0;
      hold      <= '0;
    end else begin
      if (finish) closed <= 1'b0;
      if (fire && s_last) closed <= 1'b1;
      if (take && !have) closed <= 1'b1;  // underrun ends the packet

      if (take && hold_full) begin
        hold_full <= 1'b0;
      end else if (fire && !take) begin
        hold      <= s_data;
        hold_full <= 1'b1;
      end
    end
  end

  // R9
  last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && s_last) |=> !s_ready);

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> (hold_full && $stable(hold)));

endmodule

// File: rtl/lstx_serial.sv
module lstx_serial
  import lstx_pkg::*;
#(
  parameter int unsigned        DATA_W    = 8,
  parameter int unsigned        STUFF_RUN = 6,
  parameter int unsigned        SE0_BITS  = 2,
  parameter logic [DATA_W-1:0]  SYNC_BYTE = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              pending,
  input  logic              have,
  input  logic [DATA_W-1:0] nxt_data,
  output logic              take,
  output logic              finish,
  output logic              accept_en,
  output tx_state_e         state_o,
  output logic              line_k
);

  localparam int unsigned BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned RUN_W  = $clog2(STUFF_RUN + 1);
  localparam int unsigned EOP_W  = $clog2(SE0_BITS + 1);
  localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(DATA_W - 1);
  localparam logic [RUN_W-1:0]  RUN_MAX   = RUN_W'(STUFF_RUN);
  localparam logic [EOP_W-1:0]  EOP_LAST  = EOP_W'(SE0_BITS - 1);

  tx_state_e         state;
  logic [DATA_W-1:0] sh;
  logic [BIDX_W-1:0] bidx;
  logic              cur_valid;
  logic [RUN_W-1:0]  run;
  logic [EOP_W-1:0]  eop_cnt;

  logic stepping;
  logic stuff_now;
  logic cur_bit;

  assign stepping  = bit_en && (state == ST_PREJ || state == ST_DATA);
  assign stuff_now = (run == RUN_MAX);
  assign cur_bit   = sh[bidx];
  assign take      = stepping && !stuff_now && cur_valid && (bidx == BIDX_LAST);
  assign finish    = bit_en && (state == ST_EOPJ);
  assign accept_en = (state == ST_IDLE) || (state == ST_PREJ) || (state == ST_DATA);
  assign state_o   = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sh        <= '0;
      bidx      <= '0;
      cur_valid <= 1'b0;
      run       <= '0;
      line_k    <= 1'b0;
      eop_cnt   <= '0;
    end else if (bit_en) begin
      case (state)
        ST_IDLE: begin
          if (pending) begin
            state     <= ST_PREJ;
            sh        <= SYNC_BYTE;
            bidx      <= '0;
            cur_valid <= 1'b1;
            run       <= '0;
            line_k    <= 1'b0;
          end
        end
        ST_PREJ, ST_DATA: begin
          if (stuff_now) begin
            state  <= ST_DATA;
            line_k <= !line_k;
            run    <= '0;
          end else if (cur_valid) begin
            state <= ST_DATA;
            if (!cur_bit) begin
              line_k <= !line_k;
              run    <= '0;
            end else begin
              run <= run + RUN_W'(1);
            end
            if (bidx == BIDX_LAST) begin
              bidx <= '0;
              if (have) sh <= nxt_data;
              else      cur_valid <= 1'b0;
            end else begin
              bidx <= bidx + BIDX_W'(1);
            end
          end else begin
            state   <= ST_SE0;
            eop_cnt <= '0;
          end
        end
        ST_SE0: begin
          if (eop_cnt == EOP_LAST) state <= ST_EOPJ;
          else                     eop_cnt <= eop_cnt + EOP_W'(1);
        end
        ST_EOPJ: begin
          state  <= ST_IDLE;
          line_k <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_MAX);

  // R6
  stuff_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && stuff_now) |=> (line_k != $past(line_k)));

endmodule

// File: rtl/lstx_line.sv
module lstx_line
  import lstx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tx_state_e state,
  input  logic      line_k,
  output logic      oe,
  output logic      dp,
  output logic      dm
);

  always_comb begin
    oe = 1'b1;
    dp = 1'b0;
    dm = 1'b1;
    case (state)
      ST_IDLE: begin
        oe = 1'b0;
        dm = 1'b0;
      end
      ST_DATA: begin
        dp = line_k;
        dm = !line_k;
      end
      ST_SE0: dm = 1'b0;
      default: ;
    endcase
  end

  // R4
  line_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !(dp && dm));

endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx
  import lstx_pkg::*;
#(
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       STUFF_RUN = 6,
  parameter int unsigned       SE0_BITS  = 2,
  parameter logic [DATA_W-1:0] SYNC_BYTE = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              busy,
  output logic              bus_oe,
  output logic              bus_dp,
  output logic              bus_dm
);

  logic              take;
  logic              finish;
  logic              accept_en;
  logic              pending;
  logic              have;
  logic [DATA_W-1:0] nxt_data;
  tx_state_e         state_w;
  logic              line_k;

  lstx_feed #(.DATA_W(DATA_W)) feed_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .accept_en(accept_en), .take(take), .finish(finish),
    .pending(pending), .have(have), .nxt_data(nxt_data)
  );

  lstx_serial #(
    .DATA_W(DATA_W), .STUFF_RUN(STUFF_RUN),
    .SE0_BITS(SE0_BITS), .SYNC_BYTE(SYNC_BYTE)
  ) serial_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .pending(pending), .have(have), .nxt_data(nxt_data),
    .take(take), .finish(finish), .accept_en(accept_en),
    .state_o(state_w), .line_k(line_k)
  );

  lstx_line line_i (
    .clk(clk), .rst_n(rst_n), .state(state_w), .line_k(line_k),
    .oe(bus_oe), .dp(bus_dp), .dm(bus_dm)
  );

  assign busy = (state_w != ST_IDLE);

  // R12
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable({bus_oe, bus_dp, bus_dm}));

  // R8
  eop_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_EOPJ) |-> (bus_oe && bus_dm && !bus_dp));

endmodule

// File: tb/ls_pkt_tx_tb_top.sv
module ls_pkt_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       s_last = 1'b0;
  logic       busy, bus_oe, bus_dp, bus_dm;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // symbols: 0 released, 1 J, 2 K, 3 SE0
  int exp_s [256];
  int exp_n;
  int got [256];
  int got_n;
  int unstable, busy_mis, ready_eop;
  int div = 0;

  // count byte in [39:32], bytes in [31:0] with the first byte in [7:0]
  localparam logic [39:0] VECS [6] = '{
    40'h01_000000D2,  // R13 handshake
    40'h02_0000FFFF,  // R6 run across byte boundary
    40'h01_0000003F,  // R6 run across sync boundary
    40'h03_00AA5500,  // R4 R5 toggles
    40'h02_0000FC11,  // R7 trailing stuff
    40'h04_78563412   // R5 four bytes
  };

  ls_pkt_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .busy(busy), .bus_oe(bus_oe), .bus_dp(bus_dp), .bus_dm(bus_dm)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div    <= (div == 3) ? 0 : div + 1;
    bit_en <= (div == 3);
  end

  function automatic int cur_sym();
    if (!bus_oe) return 0;
    case ({bus_dp, bus_dm})
      2'b01:   return 1;
      2'b10:   return 2;
      2'b00:   return 3;
      default: return 7;
    endcase
  endfunction

  function automatic string vec_req(int i);
    case (i)
      0: return "R13";
      1: return "R6";
      2: return "R6";
      3: return "R4";
      4: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int s);
    exp_s[exp_n] = s;
    exp_n++;
  endtask

  task automatic build_exp(input int n, input logic [31:0] b);
    int lvl = 1;
    int run = 0;
    logic [7:0] by;
    exp_n = 0;
    push(1);
    for (int k = -1; k < n; k++) begin
      by = (k < 0) ? 8'h80 : b[8*k +: 8];
      for (int i = 0; i < 8; i++) begin
        if (run == 6) begin lvl = 3 - lvl; push(lvl); run = 0; end
        if (!by[i]) begin lvl = 3 - lvl; run = 0; end
        else run++;
        push(lvl);
      end
    end
    if (run == 6) begin lvl = 3 - lvl; push(lvl); end
    push(3); push(3); push(1);
  endtask

  task automatic send_bytes(input int n, input logic [31:0] b, input bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = b[8*i +: 8];
      s_last  = with_last && (i == n - 1);
      forever begin
        if (s_ready) begin @(posedge clk); break; end
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic capture();
    bit tick_pend = 0;
    bit started = 0;
    int last = 0;
    int idle_ticks = 0;
    int s;
    got_n = 0; unstable = 0; busy_mis = 0; ready_eop = 0;
    forever begin
      @(negedge clk);
      s = cur_sym();
      if (started && s == 3 && s_ready) ready_eop++;
      if (tick_pend) begin
        if (busy !== bus_oe) busy_mis++;
        if (s != 0) begin
          started = 1;
          if (got_n < 256) got[got_n] = s;
          got_n++;
          last = s;
        end else if (started) begin
          break;
        end else begin
          idle_ticks++;
          if (idle_ticks > 200) break;
        end
      end else if (started && s != last) begin
        unstable++;
      end
      tick_pend = bit_en;
    end
  endtask

  task automatic compare(input string tag);
    int bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got[i] != exp_s[i]) bad = i;
    chk(got_n == exp_n, tag, "bit periods on the wire", got_n, exp_n);
    if (bad >= 0) chk(1'b0, tag, $sformatf("line symbol at period %0d", bad), got[bad], exp_s[bad]);
    else          chk(1'b1, tag, "line symbols", 0, 0);
    chk(got_n > 0 && got[0] == 1, "R2", "first driven symbol", got[0], 1);
    chk(busy_mis == 0, "R11", "busy/oe mismatches", busy_mis, 0);
    chk(unstable == 0, "R12", "changes between ticks", unstable, 0);
    chk(ready_eop == 0, "R9", "ready seen during SE0", ready_eop, 0);
  endtask

  task automatic run_pkt(input int n, input logic [31:0] b, input string tag);
    build_exp(n, b);
    fork
      send_bytes(n, b, 1'b1);
      capture();
    join
    compare(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_oe == 1'b0, "R1", "oe after reset", bus_oe, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(s_ready == 1'b1, "R1", "ready after reset", s_ready, 1);
    chk({bus_dp, bus_dm} == 2'b00, "R1", "lines after reset", {bus_dp, bus_dm}, 0);

    // R3 R4 R5 R6 R7 R8 through the vector table
    for (int v = 0; v < 6; v++)
      run_pkt(int'(VECS[v][39:32]), VECS[v][31:0], vec_req(v));

    // R10 underrun, with a late byte offered during end-of-packet
    fork
      begin
        send_bytes(2, 32'h0000_0201, 1'b0);
        forever begin @(negedge clk); if (cur_sym() == 3) break; end
        s_valid = 1'b1;
        s_data  = 8'h99;
        s_last  = 1'b1;
        forever begin
          if (s_ready) begin @(posedge clk); break; end
          @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
      end
      begin
        build_exp(2, 32'h0000_0201);
        capture();
        compare("R10");
        build_exp(1, 32'h0000_0099);
        capture();
        compare("R10");
      end
    join

    // R1 back to idle after the run
    repeat (8) @(negedge clk);
    chk(bus_oe == 1'b0 && busy == 1'b0, "R1", "idle after packets", {busy, bus_oe}, 0);
    chk(s_ready == 1'b1, "R1", "ready when idle", s_ready, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule